// File: doc/BRIEF.md
# Video Word to Pixel Unpacker

This block sits between a video-memory read path and a display timing engine. It accepts 32-bit words over a valid/ready handshake and emits one RGB pixel per clock while the data-enable input is high. Each colour channel leaves the block as 8 bits, together with a separate intensity bit.

Two pixel depths are handled. In 16 bits per pixel, each word carries two pixels. Their layout is either 5:6:5 or 5:5:5 followed by an intensity bit. Two controls set the order in which those pixels appear: one exchanges the two bytes inside each half-word, and one exchanges the two half-words. In 24 bits per pixel, a word carries one pixel, and a select input picks whether the colour sits in the upper or the lower three bytes.

The configuration is taken together with each word, so a change on the configuration pins affects only the words accepted after it. The usual setup for a 16-bit panel is 16 bpp, 5:6:5, half-word exchange on and byte exchange off. The internal configuration register resets to that setup.

Top module: `pxu_unpacker`

## Requirements
- R1: After a synchronous reset, `pix_en`, `pix_i` and all colour outputs are 0, and `word_ready` is 1.
- R2: With `cfg_fmt565`=1 in 16 bpp, a pixel p gives R=p[15:11], G=p[10:5] and B=p[4:0]. Each channel is widened to 8 bits by repeating its top bits below it (5-bit x becomes {x,x[4:2]}, 6-bit x becomes {x,x[5:4]}), and `pix_i`=0.
- R3: With `cfg_fmt565`=0 in 16 bpp, R=p[15:11], G=p[10:6], B=p[5:1] (each widened as in R2), and `pix_i`=p[0].
- R4: In 16 bpp with both exchange controls off, bits [15:0] of the word are shown first and bits [31:16] second.
- R5: With `cfg_swap_halves`=1 in 16 bpp, the upper half-word is shown first and the lower half-word second.
- R6: With `cfg_swap_bytes`=1 in 16 bpp, the two bytes inside each half-word are exchanged before the half-word exchange and decoding are applied.
- R7: With `cfg_bpp24`=1, each word yields one pixel. With `cfg_msb24`=0, R, G and B are bits [23:16], [15:8] and [7:0]. With `cfg_msb24`=1, they are bits [31:24], [23:16] and [15:8]. Both exchange controls are ignored and `pix_i`=0.
- R8: `word_ready` is 1 only when no pixel of the held word remains, or when exactly one remains and `de` is 1. While a 16 bpp word still holds both its pixels, `word_ready` is 0. The configuration pins are sampled only on the edge that accepts a word.
- R9: When `de` is 1 and no pixel is held, a black pixel (all colour bits and `pix_i` 0) is emitted. When `de` is 0, no pixel is consumed and the outputs are black.
- R10: `pix_en` equals `de` delayed by one clock. The pixel for a cycle with `de`=1 appears on the outputs after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A memory word is offered |
| word_data | input | 32 | Offered memory word |
| word_ready | output | 1 | Block takes the word on this edge if valid |
| cfg_bpp24 | input | 1 | 1 = 24 bpp, 0 = 16 bpp |
| cfg_fmt565 | input | 1 | 16 bpp layout: 1 = 5:6:5, 0 = 5:5:5 plus intensity |
| cfg_swap_bytes | input | 1 | Exchange bytes inside each half-word |
| cfg_swap_halves | input | 1 | Exchange the two half-words |
| cfg_msb24 | input | 1 | 24 bpp colour in upper three bytes |
| de | input | 1 | Data enable: a pixel is wanted this cycle |
| pix_en | output | 1 | Registered data enable for the output pixel |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |
| pix_i | output | 1 | Intensity bit |

## Verification
The risky overlap is the emission of the last pixel of a word in the same cycle that a new word is accepted. In that cycle the slot counter must reload, not decrement, and the emitted pixel must still come from the old word. The bench sets this up by holding a one-pixel word and raising `de` and `word_valid` together. It checks that `word_ready` is high before the edge, that the old pixel comes out on that edge, and that the new word's pixel follows on the next edge without a black gap.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CH_W    = 8;
    localparam int RGB24_W = 3 * BYTE_W;
    localparam int HALVES  = WORD_W / HALF_W;
    localparam int CNT_W   = $clog2(HALVES + 1);

    typedef struct packed {
        logic            inten;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } pix_t;

    typedef struct packed {
        logic bpp24;
        logic fmt565;
        logic swap_b;
        logic swap_h;
        logic msb24;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{bpp24: 1'b0, fmt565: 1'b1, swap_b: 1'b0,
                                   swap_h: 1'b1, msb24: 1'b0};

    localparam pix_t PIX_BLACK = '0;

    function automatic logic [CH_W-1:0] widen5(input logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen6(input logic [5:0] x);
        return {x, x[5:4]};
    endfunction

endpackage

// File: rtl/pxu_word_order.sv
module pxu_word_order
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              swap_b,
    input  logic              swap_h,
    output logic [HALF_W-1:0] first_half,
    output logic [HALF_W-1:0] second_half
);
    logic [HALF_W-1:0] halves [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HALF_W-1:0] raw;
        assign raw = word[h*HALF_W +: HALF_W];
        always_comb begin
            if (swap_b) halves[h] = {raw[BYTE_W-1:0], raw[HALF_W-1:BYTE_W]};
            else        halves[h] = raw;
        end
    end

    always_comb begin
        if (swap_h) begin
            first_half  = halves[1];
            second_half = halves[0];
        end else begin
            first_half  = halves[0];
            second_half = halves[1];
        end
    end
endmodule

// File: rtl/pxu_pixel_decode.sv
module pxu_pixel_decode
    import pxu_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    input  logic [WORD_W-1:0] word,
    input  cfg_t              cfg,
    output pix_t              pix
);
    logic [RGB24_W-1:0] chunk;

    always_comb begin
        chunk = cfg.msb24 ? word[WORD_W-1 -: RGB24_W] : word[RGB24_W-1:0];
        pix   = PIX_BLACK;
        if (cfg.bpp24) begin
            pix.r = chunk[3*BYTE_W-1 -: BYTE_W];
            pix.g = chunk[2*BYTE_W-1 -: BYTE_W];
            pix.b = chunk[BYTE_W-1:0];
        end else if (cfg.fmt565) begin
            pix.r = widen5(half[15:11]);
            pix.g = widen6(half[10:5]);
            pix.b = widen5(half[4:0]);
        end else begin
            pix.r     = widen5(half[15:11]);
            pix.g     = widen5(half[10:6]);
            pix.b     = widen5(half[5:1]);
            pix.inten = half[0];
        end
    end
endmodule

// File: rtl/pxu_slot_ctrl.sv
module pxu_slot_ctrl
    import pxu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic de,
    input  logic word_valid,
    input  logic load_one,
    output logic word_ready,
    output logic accept,
    output logic emit,
    output logic use_second
);
    logic [CNT_W-1:0] left_q;

    assign word_ready = (left_q == '0) || (left_q == CNT_W'(1) && de);
    assign accept     = word_valid && word_ready;
    assign emit       = de && (left_q != '0);
    assign use_second = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)          left_q <= '0;
        else if (accept)  left_q <= load_one ? CNT_W'(1) : CNT_W'(HALVES);
        else if (emit)    left_q <= left_q - CNT_W'(1);
    end
endmodule

// File: rtl/pxu_unpacker.sv
module pxu_unpacker
    import pxu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    output logic        word_ready,
    input  logic        cfg_bpp24,
    input  logic        cfg_fmt565,
    input  logic        cfg_swap_bytes,
    input  logic        cfg_swap_halves,
    input  logic        cfg_msb24,
    input  logic        de,
    output logic        pix_en,
    output logic [7:0]  pix_r,
    output logic [7:0]  pix_g,
    output logic [7:0]  pix_b,
    output logic        pix_i
);
    cfg_t              cfg_in, cfg_q;
    logic [WORD_W-1:0] word_q;
    logic [HALF_W-1:0] h_first, h_second, h_sel;
    logic              accept, emit, use_second;
    pix_t              dec_pix, pix_q;
    logic              de_q, px16_q, fmt565_q;

    assign cfg_in = '{bpp24: cfg_bpp24, fmt565: cfg_fmt565, swap_b: cfg_swap_bytes,
                      swap_h: cfg_swap_halves, msb24: cfg_msb24};

    pxu_slot_ctrl u_slot (
        .clk        (clk),
        .rst        (rst),
        .de         (de),
        .word_valid (word_valid),
        .load_one   (cfg_bpp24),
        .word_ready (word_ready),
        .accept     (accept),
        .emit       (emit),
        .use_second (use_second)
    );

    pxu_word_order u_order (
        .word        (word_q),
        .swap_b      (cfg_q.swap_b),
        .swap_h      (cfg_q.swap_h),
        .first_half  (h_first),
        .second_half (h_second)
    );

    assign h_sel = use_second ? h_second : h_first;

    pxu_pixel_decode u_dec (
        .half (h_sel),
        .word (word_q),
        .cfg  (cfg_q),
        .pix  (dec_pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            cfg_q    <= CFG_RESET;
            pix_q    <= PIX_BLACK;
            de_q     <= 1'b0;
            px16_q   <= 1'b0;
            fmt565_q <= 1'b0;
        end else begin
            if (accept) begin
                word_q <= word_data;
                cfg_q  <= cfg_in;
            end
            de_q     <= de;
            pix_q    <= emit ? dec_pix : PIX_BLACK;
            px16_q   <= emit && !cfg_q.bpp24;
            fmt565_q <= cfg_q.fmt565;
        end
    end

    assign pix_en = de_q;
    assign pix_r  = pix_q.r;
    assign pix_g  = pix_q.g;
    assign pix_b  = pix_q.b;
    assign pix_i  = pix_q.inten;
endmodule

// File: rtl/pxu_unpacker_chk.sv
module pxu_unpacker_chk (
    input logic       clk,
    input logic       rst,
    input logic       word_valid,
    input logic       word_ready,
    input logic       cfg_bpp24,
    input logic       de,
    input logic       pix_en,
    input logic [7:0] pix_r,
    input logic [7:0] pix_g,
    input logic [7:0] pix_b,
    input logic       pix_i,
    input logic       px16_q,
    input logic       fmt565_q
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!pix_en && word_ready && pix_r == 8'd0 && !pix_i)); // R1

    AST_RED_WIDEN: assert property (@(posedge clk) disable iff (rst)
        (pix_en && px16_q) |-> (pix_r[2:0] == pix_r[7:5] && pix_b[2:0] == pix_b[7:5])); // R2

    AST_GREEN_565: assert property (@(posedge clk) disable iff (rst)
        (pix_en && px16_q && fmt565_q) |-> (pix_g[1:0] == pix_g[7:6] && !pix_i)); // R2

    AST_GREEN_5551: assert property (@(posedge clk) disable iff (rst)
        (pix_en && px16_q && !fmt565_q) |-> (pix_g[2:0] == pix_g[7:5])); // R3

    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_ready && !cfg_bpp24) |=> !word_ready); // R8

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
        !pix_en |-> (pix_r == 8'd0 && pix_g == 8'd0 && pix_b == 8'd0 && !pix_i)); // R9

    AST_EN_ON: assert property (@(posedge clk) disable iff (rst)
        de |=> pix_en); // R10

    AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
        !de |=> !pix_en); // R10
endmodule

bind pxu_unpacker pxu_unpacker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .cfg_bpp24  (cfg_bpp24),
    .de         (de),
    .pix_en     (pix_en),
    .pix_r      (pix_r),
    .pix_g      (pix_g),
    .pix_b      (pix_b),
    .pix_i      (pix_i),
    .px16_q     (px16_q),
    .fmt565_q   (fmt565_q)
);

// File: tb/tb_pxu_unpacker.sv
module tb_pxu_unpacker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        cfg_bpp24 = 1'b0, cfg_fmt565 = 1'b1, cfg_swap_bytes = 1'b0;
    logic        cfg_swap_halves = 1'b0, cfg_msb24 = 1'b0;
    logic        de = 1'b0;
    logic        pix_en, pix_i;
    logic [7:0]  pix_r, pix_g, pix_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    pxu_unpacker dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        b24;
        logic        f565;
        logic        bs;
        logic        hs;
        logic        msb;
        logic [31:0] w;
        logic [24:0] e0;
        logic [24:0] e1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hF800_001F, {1'b0, 24'h0000FF}, {1'b0, 24'hFF0000}}, // R2 R4
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hF800_001F, {1'b0, 24'hFF0000}, {1'b0, 24'h0000FF}}, // R5
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00F8_1F00, {1'b0, 24'h0000FF}, {1'b0, 24'hFF0000}}, // R6
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h07C0_0001, {1'b1, 24'h000000}, {1'b0, 24'h00FF00}}, // R3
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_8410, {1'b0, 24'h848284}, {1'b0, 24'h000000}}, // R2 widening
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hAA12_3456, {1'b0, 24'h123456}, {1'b0, 24'h000000}}, // R7 low
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h1234_56AA, {1'b0, 24'h123456}, {1'b0, 24'h000000}}, // R7 high
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h3E00_0000, {1'b0, 24'h0000FF}, {1'b0, 24'h000000}}  // R3 R5 R6
    };

    function automatic logic [24:0] px();
        return {pix_i, pix_r, pix_g, pix_b};
    endfunction

    task automatic chk(input string req, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic b24, input logic f565, input logic bs,
                           input logic hs, input logic msb);
        cfg_bpp24 = b24; cfg_fmt565 = f565; cfg_swap_bytes = bs;
        cfg_swap_halves = hs; cfg_msb24 = msb;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 pixel", px(), 25'd0);
        chk("R1 pix_en/ready", {23'd0, pix_en, word_ready}, {23'd0, 1'b0, 1'b1});

        // R9: underflow gives black with enable high
        de = 1'b1;
        step();
        chk("R9 underflow", {pix_en, px()}, {1'b1, 25'd0});
        de = 1'b0;
        step();

        // table walk
        for (int k = 0; k < NV; k++) begin
            set_cfg(VT[k].b24, VT[k].f565, VT[k].bs, VT[k].hs, VT[k].msb);
            word_data  = VT[k].w;
            word_valid = 1'b1;
            step();
            word_valid = 1'b0;
            if (!VT[k].b24) chk("R8 ready low while full", {24'd0, word_ready}, 25'd0);
            de = 1'b1;
            step();
            chk($sformatf("table row %0d first pixel", k), px(), VT[k].e0);
            if (!VT[k].b24) begin
                step();
                chk($sformatf("table row %0d second pixel", k), px(), VT[k].e1);
            end
            de = 1'b0;
            step();
            chk("R9 de low black", {pix_en, px()}, 26'd0);
        end

        // R8: config sampled at acceptance only
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        word_data  = 32'h0000_0001;
        word_valid = 1'b1;
        step();
        word_valid = 1'b0;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R9: idle with de low consumes nothing
        step();
        step();
        chk("R9 nothing consumed, still full", {24'd0, word_ready}, 25'd0);
        de = 1'b1;
        step();
        chk("R8 latched 565 config", px(), {1'b0, 24'h000008});
        step();
        chk("R4 upper half second", px(), 25'd0);
        de = 1'b0;
        step();

        // R8: last pixel out and new word in on the same edge
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        word_data  = 32'h0011_2233;
        word_valid = 1'b1;
        step();
        word_data = 32'h00AB_CDEF;
        de        = 1'b1;
        #1;
        chk("R8 ready with one left and de", {24'd0, word_ready}, 25'd1);
        step();
        word_valid = 1'b0;
        chk("R8 old pixel on overlap edge", px(), {1'b0, 24'h112233});
        step();
        chk("R8 new pixel without gap", {pix_en, px()}, {1'b1, 1'b0, 24'hABCDEF});
        de = 1'b0;
        step();
        chk("R10 enable drops after de", {24'd0, pix_en}, 25'd0);

        done = 1'b1;
        finish_run();
    end
endmodule